// File: doc/BRIEF.md
# Calibration Watchdog with Interrupt

This block guards the precision level of a CAN clock-calibration state machine. The host programs a 16-bit start value. When the calibration state enters precision-calibrated, a down-counter is loaded with that value. The counter then loses one count for every sample-point pulse that the protocol engine sends. Those pulses exist only while the engine is running. If the count runs out before calibration is confirmed again, the block takes the calibration state back to basic-calibrated and emits a single-clock watchdog event.

The event also sets a sticky interrupt flag. When its enable bit is set, the flag drives the interrupt line until software clears it with a write-one-to-clear access. Software changes the start value only while the configuration-change-enable input is high. The sample-point pulse arrives asynchronously. It passes through a synchroniser, and only its rising edge is used. The calibration state is held here as a stub register, which the surrounding calibration logic (or a testbench) sets through a small update port.

Top module: `cal_wdog_top`

## Requirements
- R1: The counter decrements by exactly one per sample-point pulse, however many system clocks the pulse lasts. It decrements only while the calibration state is precision-calibrated (2'b10). In any other state it does not move.
- R2: On each transition of the calibration state into precision-calibrated, the counter reloads from the start value. The transition comes from the update port with value 2'b10.
- R3: When the counter reaches zero, the calibration state becomes basic-calibrated (2'b01). The state encoding is 00 not calibrated, 01 basic, 10 precision and 11 reserved. An expiry takes priority over a stub update in the same cycle.
- R4: Each expiry raises `wd_event` for exactly one system clock cycle.
- R5: An expiry sets the interrupt flag (register 2, bit 0). The flag stays set until software writes 1 to that bit. Writing 0 leaves it unchanged, and a set in the same cycle as a clear wins.
- R6: `irq` is high while the flag is set and the enable bit (register 3, bit 0) is 1. It stays high until the flag is cleared.
- R7: After expiry the counter holds at zero and does not wrap, even when further pulses arrive.
- R8: A start value of zero disables the watchdog. No decrement happens and no event is produced.
- R9: A write to the start value (register 0, bits 15:0) takes effect only while `cce` is 1. Otherwise the write is ignored.
- R10: The register map is as follows. Register 0 holds the start value in bits 15:0 and the live count in bits 31:16 (read-only). Register 1 bits 1:0 hold the calibration state (read-only). Register 2 bit 0 is the flag, and register 3 bit 0 is the enable. After reset every register reads 0, and `irq` and `wd_event` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous hard reset |
| spt_in | input | 1 | Sample-point pulse from the protocol engine (asynchronous) |
| cce | input | 1 | Configuration-change enable; gates protected writes |
| cal_set_vld | input | 1 | Stub update strobe for the calibration state |
| cal_set_state | input | 2 | Calibration state value to load on the strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from address) |
| cal_state | output | 2 | Current calibration state |
| wd_event | output | 1 | One-cycle watchdog expiry event |
| irq | output | 1 | Interrupt line |

## Verification
Each sample-point pulse is held high for several system clocks. A design that decremented on the level instead of the edge would therefore lose several counts per pulse and expire early. The bench sends pulses past expiry to catch a counter that wraps to all ones, and it uses a zero start value to catch a design that fires an event at once. Two further corner cases are covered. A write of 0 to the flag must leave the interrupt asserted, and a start-value write while `cce` is low must be ignored. A design that missed the first would drop the interrupt, and one that missed the second would let software silently change the timeout.

// File: rtl/cal_wdog_pkg.sv
package cal_wdog_pkg;

  typedef enum logic [1:0] {
    CAL_NONE  = 2'b00,
    CAL_BASIC = 2'b01,
    CAL_PREC  = 2'b10,
    CAL_RSVD  = 2'b11
  } cal_state_e;

  localparam logic [1:0] ADDR_WDOG  = 2'd0;
  localparam logic [1:0] ADDR_STATE = 2'd1;
  localparam logic [1:0] ADDR_FLAG  = 2'd2;
  localparam logic [1:0] ADDR_EN    = 2'd3;

endpackage

// File: rtl/cal_wdog_spt_sync.sv
module cal_wdog_spt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic spt_in,
  output logic spt_edge
);
  logic [STAGES:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shreg <= '0;
    else        shreg <= {shreg[STAGES-1:0], spt_in};
  end

  // rising edge seen after the synchroniser stages
  assign spt_edge = shreg[STAGES-1] & ~shreg[STAGES];
endmodule

// File: rtl/cal_wdog_core.sv
module cal_wdog_core
  import cal_wdog_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             spt_edge,
  input  logic [CNT_W-1:0] start_val,
  input  logic             cal_set_vld,
  input  logic [1:0]       cal_set_state,
  output logic [CNT_W-1:0] cnt,
  output cal_state_e       cal_state,
  output logic             expire,
  output logic             reload,
  output logic             wd_event
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  function automatic logic f_counting(input logic edge_i,
                                      input cal_state_e st,
                                      input logic [CNT_W-1:0] start,
                                      input logic [CNT_W-1:0] cur);
    return edge_i && (st == CAL_PREC) && (start != '0) && (cur != '0);
  endfunction

  function automatic logic [CNT_W-1:0] f_next(input logic rld,
                                              input logic dec,
                                              input logic [CNT_W-1:0] start,
                                              input logic [CNT_W-1:0] cur);
    if (rld)      return start;
    else if (dec) return cur - ONE;
    else          return cur;
  endfunction

  logic dec;
  cal_state_e state_nxt;

  assign dec    = f_counting(spt_edge, cal_state, start_val, cnt);
  assign expire = dec && (cnt == ONE);
  assign reload = cal_set_vld && (cal_set_state == CAL_PREC) &&
                  (cal_state != CAL_PREC) && !expire;

  always_comb begin
    if (expire)           state_nxt = CAL_BASIC;
    else if (cal_set_vld) state_nxt = cal_state_e'(cal_set_state);
    else                  state_nxt = cal_state;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      cal_state <= CAL_NONE;
      wd_event  <= 1'b0;
    end else begin
      cnt       <= f_next(reload, dec, start_val, cnt);
      cal_state <= state_nxt;
      wd_event  <= expire;
    end
  end
endmodule

// File: rtl/cal_wdog_regs.sv
module cal_wdog_regs
  import cal_wdog_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic [1:0]         reg_addr,
  input  logic [2*CNT_W-1:0] reg_wdata,
  input  logic               cce,
  input  logic               expire,
  input  logic [CNT_W-1:0]   cnt,
  input  cal_state_e         cal_state,
  output logic [CNT_W-1:0]   start_val,
  output logic               cwe_flag,
  output logic               cwe_en,
  output logic [2*CNT_W-1:0] reg_rdata
);
  localparam int DATA_W = 2 * CNT_W;

  logic wr_start, wr_flag, wr_en;
  assign wr_start = reg_wr && (reg_addr == ADDR_WDOG) && cce;
  assign wr_flag  = reg_wr && (reg_addr == ADDR_FLAG);
  assign wr_en    = reg_wr && (reg_addr == ADDR_EN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_val <= '0;
      cwe_flag  <= 1'b0;
      cwe_en    <= 1'b0;
    end else begin
      if (wr_start) start_val <= reg_wdata[CNT_W-1:0];
      if (expire)                      cwe_flag <= 1'b1;
      else if (wr_flag && reg_wdata[0]) cwe_flag <= 1'b0;
      if (wr_en) cwe_en <= reg_wdata[0];
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADDR_WDOG:  reg_rdata = {cnt, start_val};
      ADDR_STATE: reg_rdata = DATA_W'(cal_state);
      ADDR_FLAG:  reg_rdata = DATA_W'(cwe_flag);
      default:    reg_rdata = DATA_W'(cwe_en);
    endcase
  end
endmodule

// File: rtl/cal_wdog_top.sv
module cal_wdog_top
  import cal_wdog_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               spt_in,
  input  logic               cce,
  input  logic               cal_set_vld,
  input  logic [1:0]         cal_set_state,
  input  logic               reg_wr,
  input  logic [1:0]         reg_addr,
  input  logic [2*CNT_W-1:0] reg_wdata,
  output logic [2*CNT_W-1:0] reg_rdata,
  output logic [1:0]         cal_state,
  output logic               wd_event,
  output logic               irq
);
  logic             spt_edge;
  logic [CNT_W-1:0] start_val;
  logic [CNT_W-1:0] cnt;
  logic             expire;
  logic             reload;
  logic             cwe_flag;
  logic             cwe_en;
  cal_state_e       st;

  cal_wdog_spt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .spt_in(spt_in), .spt_edge(spt_edge)
  );

  cal_wdog_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .spt_edge(spt_edge), .start_val(start_val),
    .cal_set_vld(cal_set_vld), .cal_set_state(cal_set_state),
    .cnt(cnt), .cal_state(st), .expire(expire), .reload(reload),
    .wd_event(wd_event)
  );

  cal_wdog_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .cce(cce), .expire(expire), .cnt(cnt),
    .cal_state(st), .start_val(start_val), .cwe_flag(cwe_flag),
    .cwe_en(cwe_en), .reg_rdata(reg_rdata)
  );

  assign cal_state = st;
  assign irq       = cwe_flag & cwe_en;
endmodule

// File: rtl/cal_wdog_chk.sv
module cal_wdog_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             spt_edge,
  input logic             reload,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] start_val,
  input logic [1:0]       cal_state,
  input logic             wd_event,
  input logic             cwe_flag,
  input logic             cce,
  input logic             reg_wr,
  input logic [1:0]       reg_addr
);
  assert_dec_once_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (spt_edge && cnt != '0 && start_val != '0 && cal_state == 2'b10 && !reload)
      |=> (cnt == $past(cnt) - CNT_W'(1)));

  assert_reload_R2: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> (cnt == $past(start_val)));

  assert_expiry_state_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wd_event |-> (cal_state == 2'b01 && cnt == '0));

  assert_event_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wd_event |=> !wd_event);

  assert_flag_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wd_event |-> cwe_flag);

  assert_no_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0 && !reload) |=> (cnt == '0));

  assert_zero_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (start_val == '0) |=> !wd_event);

  assert_protected_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!cce && reg_wr && reg_addr == 2'd0) |=> $stable(start_val));
endmodule

bind cal_wdog_top cal_wdog_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .spt_edge(spt_edge), .reload(reload),
  .cnt(cnt), .start_val(start_val), .cal_state(cal_state),
  .wd_event(wd_event), .cwe_flag(cwe_flag), .cce(cce),
  .reg_wr(reg_wr), .reg_addr(reg_addr)
);

// File: tb/sim_cal_wdog_top.sv
`timescale 1ns/1ps
module sim_cal_wdog_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        spt_in = 1'b0;
  logic        cce = 1'b0;
  logic        cal_set_vld = 1'b0;
  logic [1:0]  cal_set_state = 2'b00;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [1:0]  cal_state;
  logic        wd_event;
  logic        irq;

  int checks = 0;
  int errors = 0;
  int ev_cnt = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cal_wdog_top u0 (
    .clk(clk), .rst_n(rst_n), .spt_in(spt_in), .cce(cce),
    .cal_set_vld(cal_set_vld), .cal_set_state(cal_set_state),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .cal_state(cal_state), .wd_event(wd_event),
    .irq(irq)
  );

  always @(posedge clk) if (wd_event) ev_cnt++;

  typedef struct packed {
    logic [15:0] start;
    logic [7:0]  npulse;
    logic [15:0] exp_cnt;
    logic [1:0]  exp_st;
    logic        exp_ev;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{16'd3, 8'd1, 16'd2, 2'b10, 1'b0},
    '{16'd3, 8'd3, 16'd0, 2'b01, 1'b1},
    '{16'd2, 8'd5, 16'd0, 2'b01, 1'b1},
    '{16'd0, 8'd4, 16'd0, 2'b10, 1'b0},
    '{16'd5, 8'd4, 16'd1, 2'b10, 1'b0},
    '{16'd1, 8'd1, 16'd0, 2'b01, 1'b1}
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #0.5 d = reg_rdata;
  endtask

  task automatic set_state(input logic [1:0] s);
    @(negedge clk);
    cal_set_state = s; cal_set_vld = 1'b1;
    @(negedge clk);
    cal_set_vld = 1'b0;
  endtask

  task automatic pulse();
    @(negedge clk);
    spt_in = 1'b1;
    repeat (3) @(negedge clk);
    spt_in = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog timeout actual=0 expected=1");
      summary();
    end
  end

  initial begin
    logic [31:0] d;
    int ev0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R10 reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), d);
      chk(d == 32'h0, "R10 reset register", d, 0);
    end
    chk(irq == 1'b0, "R10 reset irq", 32'(irq), 0);
    chk(wd_event == 1'b0, "R10 reset event", 32'(wd_event), 0);

    // table of vectors: R1 R2 R3 R4 R7 R8
    cce = 1'b1;
    foreach (VECS[i]) begin
      wr(2'd0, {16'h0, VECS[i].start});
      set_state(2'b01);
      set_state(2'b10);
      ev0 = ev_cnt;
      for (int p = 0; p < int'(VECS[i].npulse); p++) pulse();
      rd(2'd0, d);
      chk(d[31:16] == VECS[i].exp_cnt, "R1/R7 count after pulses",
          32'(d[31:16]), 32'(VECS[i].exp_cnt));
      chk(cal_state == VECS[i].exp_st, "R3 state after pulses",
          32'(cal_state), 32'(VECS[i].exp_st));
      chk((ev_cnt - ev0) == int'(VECS[i].exp_ev), "R4/R8 event cycles",
          32'(ev_cnt - ev0), 32'(VECS[i].exp_ev));
      wr(2'd2, 32'h1);
    end

    // R9 protected write
    wr(2'd0, 32'd7);
    cce = 1'b0;
    wr(2'd0, 32'h1234);
    rd(2'd0, d);
    chk(d[15:0] == 16'd7, "R9 write ignored without cce", 32'(d[15:0]), 7);
    cce = 1'b1;
    wr(2'd0, 32'd4);
    rd(2'd0, d);
    chk(d[15:0] == 16'd4, "R9 write accepted with cce", 32'(d[15:0]), 4);

    // R2 reload on re-entry, R1 no count outside precision
    set_state(2'b01);
    set_state(2'b10);
    pulse(); pulse();
    rd(2'd0, d);
    chk(d[31:16] == 16'd2, "R1 two pulses", 32'(d[31:16]), 2);
    set_state(2'b01);
    pulse();
    rd(2'd0, d);
    chk(d[31:16] == 16'd2, "R1 frozen outside precision", 32'(d[31:16]), 2);
    set_state(2'b10);
    rd(2'd0, d);
    chk(d[31:16] == 16'd4, "R2 reload on entry", 32'(d[31:16]), 4);

    // R5 R6 interrupt flag and line
    wr(2'd3, 32'h1);
    wr(2'd0, 32'd1);
    set_state(2'b01);
    set_state(2'b10);
    pulse();
    chk(irq == 1'b1, "R6 irq after expiry", 32'(irq), 1);
    rd(2'd2, d);
    chk(d[0] == 1'b1, "R5 flag set", 32'(d[0]), 1);
    wr(2'd2, 32'h0);
    rd(2'd2, d);
    chk(d[0] == 1'b1 && irq == 1'b1, "R5 write 0 keeps flag", 32'(d[0]), 1);
    wr(2'd3, 32'h0);
    #0.5 chk(irq == 1'b0, "R6 irq masked", 32'(irq), 0);
    wr(2'd3, 32'h1);
    #0.5 chk(irq == 1'b1, "R6 irq held until cleared", 32'(irq), 1);
    wr(2'd2, 32'h1);
    rd(2'd2, d);
    chk(d[0] == 1'b0 && irq == 1'b0, "R5 write 1 clears", 32'(d[0]), 0);

    // R7 hold at zero after extra pulses
    pulse(); pulse();
    rd(2'd0, d);
    chk(d[31:16] == 16'd0, "R7 no wrap", 32'(d[31:16]), 0);
    chk(irq == 1'b0, "R3 no second event in basic state", 32'(irq), 0);

    done = 1'b1;
    summary();
  end
endmodule